// File: doc/BRIEF.md
# Privileged Trap-Return Unit

This block carries out the two privileged return instructions of a processor core: the return from supervisor mode and the return from machine mode. It holds the current privilege level and the interrupt-enable stack: the live enable bits, the saved enable bits and the saved privilege for each of the two upper modes. It also holds the two exception-PC registers and the trap-on-supervisor-return control bit. Trap entry and the rest of the control-register file live elsewhere. They load this block's state through a simple write port.

When the pipeline requests a return, the block checks three things in a fixed order: privilege, target alignment and the trap-on-supervisor-return control. A failing check yields one exception pulse with a cause code and leaves all state as it was. A passing request pops the enable/privilege stack, switches privilege and presents the return target on a one-cycle done pulse. The alignment check depends on an input that says whether compressed (16-bit) instructions are enabled.

Top module: `priv_return_ctrl`

## Requirements
- R1: After reset, `priv_o` is 3 (machine), `status_o` is 0x00, and `done_o` and `exc_o` are 0.
- R2: A write with `wr_en_i` high loads the target selected by `wr_sel_i`: 0 = status, 1 = supervisor exception PC, 2 = machine exception PC, 3 = privilege. The new value shows on `status_o`/`priv_o` from the next cycle. The status layout is bit 0 supervisor enable, bit 1 machine enable, bit 2 supervisor saved enable, bit 3 machine saved enable, bit 4 supervisor saved privilege (1 bit), bits 6:5 machine saved privilege, bit 7 trap-on-supervisor-return. A privilege value of 2, whether written to bits 6:5 or through select 3, is stored as 0.
- R3: A supervisor return (`ret_kind_i`=0) at privilege 0, or a machine return (`ret_kind_i`=1) at a privilege other than 3, fails with cause 2 (illegal instruction).
- R4: When `comp_en_i` is 0 and the selected exception PC has bit 1 or bit 0 set, the return fails with cause 0 (misaligned target). When `comp_en_i` is 1, no alignment check is made.
- R5: Status bit 7 set makes a supervisor return fail with cause 2. It has no effect on a machine return.
- R6: The checks are ranked privilege first, then alignment, then bit 7. Only the cause of the first failing check is reported.
- R7: A failed return leaves `priv_o` and `status_o` unchanged.
- R8: A successful supervisor return copies bit 2 into bit 0, clears bits 2 and 4, sets privilege to the old bit 4 value and returns the supervisor exception PC.
- R9: A successful machine return copies bit 3 into bit 1, clears bit 3, sets bits 6:5 to 0, sets privilege to the old bits 6:5 and returns the machine exception PC.
- R10: Each request raises exactly one of `done_o` or `exc_o`, for the single cycle after the request edge, with `target_pc_o` or `cause_o` valid in that cycle. Without a request, neither is raised.
- R11: A write presented in the same cycle as a return request is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| comp_en_i | input | 1 | Compressed instructions enabled (relaxes alignment check) |
| wr_en_i | input | 1 | State write strobe |
| wr_sel_i | input | 2 | Write target: 0 status, 1 supervisor EPC, 2 machine EPC, 3 privilege |
| wr_data_i | input | XLEN | Write data |
| ret_req_i | input | 1 | Return request |
| ret_kind_i | input | 1 | 0 supervisor return, 1 machine return |
| priv_o | output | 2 | Current privilege level |
| status_o | output | 8 | Status fields (layout in R2) |
| done_o | output | 1 | Successful return pulse |
| exc_o | output | 1 | Failed return pulse |
| cause_o | output | 4 | Exception cause, valid with exc_o |
| target_pc_o | output | XLEN | Return target, valid with done_o |

## Verification
A write becomes visible on `status_o` or `priv_o` one cycle after its edge. A return's pulse, cause, target and updated state all appear together in the one cycle after the request edge. The bench drives every input on the falling edge and samples one falling edge later, so each result is read in the cycle it is due. It checks again one cycle later to confirm that the pulse has dropped. The vector table covers each check alone and every pair that could collide in the ranking.

// File: rtl/priv_ret_pkg.sv
package priv_ret_pkg;

  localparam int unsigned PRIV_W   = 2;
  localparam int unsigned STATUS_W = 8;
  localparam int unsigned CAUSE_W  = 4;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned ALIGN_W  = 2;
  localparam int unsigned NUM_EPC  = 2;

  typedef enum logic [PRIV_W-1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUPV = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_MACH = 2'd3
  } priv_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_SEPC   = 2'd1,
    SEL_MEPC   = 2'd2,
    SEL_PRIV   = 2'd3
  } wsel_e;

  typedef struct packed {
    logic        trap_sret;
    logic [1:0]  m_prev_priv;
    logic        s_prev_priv;
    logic        m_prev_ie;
    logic        s_prev_ie;
    logic        m_ie;
    logic        s_ie;
  } status_t;

  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 4'd2;

  localparam int unsigned EPC_SUPV = 0;
  localparam int unsigned EPC_MACH = 1;

  function automatic logic [PRIV_W-1:0] legal_priv(input logic [PRIV_W-1:0] p);
    return (p == PRIV_RSVD) ? PRIV_USER : p;
  endfunction

endpackage

// File: rtl/priv_ret_epc_bank.sv
module priv_ret_epc_bank #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned NUM_REG = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_REG-1:0]             we_i,
  input  logic [XLEN-1:0]                wdata_i,
  output logic [NUM_REG-1:0][XLEN-1:0]   q_o
);

  for (genvar gi = 0; gi < NUM_REG; gi++) begin : g_reg
    logic [XLEN-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0;
      end else if (we_i[gi]) begin
        val_q <= wdata_i;
      end
    end
    assign q_o[gi] = val_q;
  end

endmodule

// File: rtl/priv_ret_check.sv
module priv_ret_check
  import priv_ret_pkg::*;
(
  input  logic                ret_kind_i,
  input  logic [PRIV_W-1:0]   priv_i,
  input  status_t             status_i,
  input  logic [ALIGN_W-1:0]  tgt_lsb_i,
  input  logic                comp_en_i,
  output logic                fault_o,
  output logic [CAUSE_W-1:0]  cause_o
);

  logic priv_bad;
  logic align_bad;
  logic tsr_bad;

  always_comb begin
    if (ret_kind_i) begin
      priv_bad = (priv_i != PRIV_MACH);
    end else begin
      priv_bad = (priv_i < PRIV_SUPV);
    end
    align_bad = !comp_en_i && (tgt_lsb_i != '0);
    tsr_bad   = !ret_kind_i && status_i.trap_sret;
  end

  always_comb begin
    fault_o = priv_bad || align_bad || tsr_bad;
    if (priv_bad) begin
      cause_o = CAUSE_ILLEGAL;
    end else if (align_bad) begin
      cause_o = CAUSE_MISALIGN;
    end else begin
      cause_o = CAUSE_ILLEGAL;
    end
  end

endmodule

// File: rtl/priv_ret_state.sv
module priv_ret_state
  import priv_ret_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_stat_i,
  input  logic                 wr_priv_i,
  input  logic [STATUS_W-1:0]  wdata_i,
  input  logic                 pop_i,
  input  logic                 pop_kind_i,
  output logic [PRIV_W-1:0]    priv_o,
  output status_t              status_o
);

  status_t             stat_q, stat_d;
  logic [PRIV_W-1:0]   priv_q, priv_d;
  logic                stat_en, priv_en;
  status_t             wr_stat;

  always_comb begin
    wr_stat             = status_t'(wdata_i);
    wr_stat.m_prev_priv = legal_priv(wr_stat.m_prev_priv);
  end

  always_comb begin
    stat_d  = stat_q;
    priv_d  = priv_q;
    stat_en = 1'b0;
    priv_en = 1'b0;
    if (pop_i) begin
      stat_en = 1'b1;
      priv_en = 1'b1;
      if (pop_kind_i) begin
        stat_d.m_ie        = stat_q.m_prev_ie;
        stat_d.m_prev_ie   = 1'b0;
        stat_d.m_prev_priv = PRIV_USER;
        priv_d             = legal_priv(stat_q.m_prev_priv);
      end else begin
        stat_d.s_ie        = stat_q.s_prev_ie;
        stat_d.s_prev_ie   = 1'b0;
        stat_d.s_prev_priv = 1'b0;
        priv_d             = {1'b0, stat_q.s_prev_priv};
      end
    end else begin
      if (wr_stat_i) begin
        stat_en = 1'b1;
        stat_d  = wr_stat;
      end
      if (wr_priv_i) begin
        priv_en = 1'b1;
        priv_d  = legal_priv(wdata_i[PRIV_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q <= PRIV_MACH;
    end else if (priv_en) begin
      priv_q <= priv_d;
    end
  end

  assign priv_o   = priv_q;
  assign status_o = stat_q;

endmodule

// File: rtl/priv_return_ctrl.sv
module priv_return_ctrl
  import priv_ret_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 comp_en_i,
  input  logic                 wr_en_i,
  input  logic [SEL_W-1:0]     wr_sel_i,
  input  logic [XLEN-1:0]      wr_data_i,
  input  logic                 ret_req_i,
  input  logic                 ret_kind_i,
  output logic [PRIV_W-1:0]    priv_o,
  output logic [STATUS_W-1:0]  status_o,
  output logic                 done_o,
  output logic                 exc_o,
  output logic [CAUSE_W-1:0]   cause_o,
  output logic [XLEN-1:0]      target_pc_o
);

  logic                          wr_ok;
  logic [NUM_EPC-1:0]            epc_we;
  logic [NUM_EPC-1:0][XLEN-1:0]  epc_q;
  logic [XLEN-1:0]               tgt_pc;
  logic [PRIV_W-1:0]             priv_cur;
  status_t                       stat_cur;
  logic                          fault;
  logic [CAUSE_W-1:0]            cause_d;
  logic                          pop;

  logic                          done_q, exc_q;
  logic [CAUSE_W-1:0]            cause_q;
  logic [XLEN-1:0]               tgt_q;

  assign wr_ok = wr_en_i && !ret_req_i;

  always_comb begin
    epc_we           = '0;
    epc_we[EPC_SUPV] = wr_ok && (wr_sel_i == SEL_SEPC);
    epc_we[EPC_MACH] = wr_ok && (wr_sel_i == SEL_MEPC);
  end

  priv_ret_epc_bank #(
    .XLEN    (XLEN),
    .NUM_REG (NUM_EPC)
  ) u_epc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (epc_we),
    .wdata_i (wr_data_i),
    .q_o     (epc_q)
  );

  assign tgt_pc = ret_kind_i ? epc_q[EPC_MACH] : epc_q[EPC_SUPV];

  priv_ret_check u_chk_logic (
    .ret_kind_i (ret_kind_i),
    .priv_i     (priv_cur),
    .status_i   (stat_cur),
    .tgt_lsb_i  (tgt_pc[ALIGN_W-1:0]),
    .comp_en_i  (comp_en_i),
    .fault_o    (fault),
    .cause_o    (cause_d)
  );

  assign pop = ret_req_i && !fault;

  priv_ret_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_stat_i  (wr_ok && (wr_sel_i == SEL_STATUS)),
    .wr_priv_i  (wr_ok && (wr_sel_i == SEL_PRIV)),
    .wdata_i    (wr_data_i[STATUS_W-1:0]),
    .pop_i      (pop),
    .pop_kind_i (ret_kind_i),
    .priv_o     (priv_cur),
    .status_o   (stat_cur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      done_q <= pop;
      exc_q  <= ret_req_i && fault;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else if (ret_req_i && fault) begin
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
    end else if (pop) begin
      tgt_q <= tgt_pc;
    end
  end

  assign priv_o      = priv_cur;
  assign status_o    = stat_cur;
  assign done_o      = done_q;
  assign exc_o       = exc_q;
  assign cause_o     = cause_q;
  assign target_pc_o = tgt_q;

endmodule

// File: rtl/priv_return_chk.sv
module priv_return_chk (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ret_req_i,
  input  logic        ret_kind_i,
  input  logic [1:0]  priv_o,
  input  logic [7:0]  status_o,
  input  logic        done_o,
  input  logic        exc_o,
  input  logic [3:0]  cause_o
);

  AST_DONE_EXC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && exc_o)); // R10

  AST_PULSE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_req_i |=> !done_o && !exc_o); // R10

  AST_PRIV_NOT_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_o != 2'd2); // R2

  AST_MRET_BELOW_M: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && ret_kind_i && (priv_o != 2'd3) |=> exc_o && (cause_o == 4'd2)); // R3

  AST_SRET_FROM_U: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && !ret_kind_i && (priv_o == 2'd0) |=> exc_o && (cause_o == 4'd2)); // R6

  AST_FAIL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> $stable(priv_o) && $stable(status_o)); // R7

  AST_SRET_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && !ret_kind_i |=> done_o |-> !status_o[2] && !status_o[4]); // R8

  AST_MRET_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_req_i && ret_kind_i |=> done_o |-> !status_o[3] && (status_o[6:5] == 2'd0)); // R9

endmodule

bind priv_return_ctrl priv_return_chk u_ret_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ret_req_i  (ret_req_i),
  .ret_kind_i (ret_kind_i),
  .priv_o     (priv_o),
  .status_o   (status_o),
  .done_o     (done_o),
  .exc_o      (exc_o),
  .cause_o    (cause_o)
);

// File: tb/sim_priv_return_ctrl.sv
module sim_priv_return_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 12;

  typedef struct packed {
    logic [1:0]  priv;
    logic [7:0]  st;
    logic [31:0] sepc;
    logic [31:0] mepc;
    logic        comp;
    logic        kind;
    logic        exc;
    logic [3:0]  cause;
    logic [1:0]  epriv;
    logic [7:0]  est;
    logic [31:0] epc;
    logic [3:0]  req;
  } vec_t;

  // priv, status, sepc, mepc, comp, kind | exc, cause, priv, status, target | req
  localparam vec_t VECS [NVEC] = '{
    '{2'd3, 8'h14, 32'h100, 32'h000, 1'b0, 1'b0, 1'b0, 4'd0, 2'd1, 8'h01, 32'h100, 4'd8}, // R8
    '{2'd3, 8'h68, 32'h000, 32'h200, 1'b0, 1'b1, 1'b0, 4'd0, 2'd3, 8'h02, 32'h200, 4'd9}, // R9
    '{2'd1, 8'h68, 32'h000, 32'h200, 1'b0, 1'b1, 1'b1, 4'd2, 2'd1, 8'h68, 32'h000, 4'd3}, // R3
    '{2'd0, 8'h14, 32'h100, 32'h000, 1'b0, 1'b0, 1'b1, 4'd2, 2'd0, 8'h14, 32'h000, 4'd3}, // R3
    '{2'd3, 8'h94, 32'h102, 32'h000, 1'b0, 1'b0, 1'b1, 4'd0, 2'd3, 8'h94, 32'h000, 4'd6}, // R6
    '{2'd3, 8'h94, 32'h102, 32'h000, 1'b1, 1'b0, 1'b1, 4'd2, 2'd3, 8'h94, 32'h000, 4'd5}, // R5
    '{2'd1, 8'h14, 32'h102, 32'h000, 1'b1, 1'b0, 1'b0, 4'd0, 2'd1, 8'h01, 32'h102, 4'd4}, // R4
    '{2'd0, 8'h14, 32'h102, 32'h000, 1'b0, 1'b0, 1'b1, 4'd2, 2'd0, 8'h14, 32'h000, 4'd6}, // R6
    '{2'd3, 8'h22, 32'h000, 32'h301, 1'b0, 1'b1, 1'b1, 4'd0, 2'd3, 8'h22, 32'h000, 4'd4}, // R4
    '{2'd3, 8'h22, 32'h000, 32'h301, 1'b1, 1'b1, 1'b0, 4'd0, 2'd1, 8'h00, 32'h301, 4'd9}, // R9
    '{2'd3, 8'hE8, 32'h000, 32'h200, 1'b0, 1'b1, 1'b0, 4'd0, 2'd3, 8'h82, 32'h200, 4'd5}, // R5
    '{2'd1, 8'h6E, 32'h100, 32'h000, 1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 8'h6B, 32'h100, 4'd8}  // R8
  };

  logic        clk;
  logic        rst_n;
  logic        comp_en;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        ret_req;
  logic        ret_kind;
  logic [1:0]  priv;
  logic [7:0]  status;
  logic        done;
  logic        exc;
  logic [3:0]  cause;
  logic [31:0] target;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  priv_return_ctrl #(.XLEN(32)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .comp_en_i   (comp_en),
    .wr_en_i     (wr_en),
    .wr_sel_i    (wr_sel),
    .wr_data_i   (wr_data),
    .ret_req_i   (ret_req),
    .ret_kind_i  (ret_kind),
    .priv_o      (priv),
    .status_o    (status),
    .done_o      (done),
    .exc_o       (exc),
    .cause_o     (cause),
    .target_pc_o (target)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      report();
    end
  end

  task automatic do_write(input logic [1:0] sel, input logic [31:0] data);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic do_return(input logic kind);
    ret_req  = 1'b1;
    ret_kind = kind;
    @(negedge clk);
    ret_req  = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; comp_en = 1'b0; wr_en = 1'b0; wr_sel = '0;
    wr_data = '0; ret_req = 1'b0; ret_kind = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 priv", {30'd0, priv}, 32'd3);
    check("R1 status", {24'd0, status}, 32'h00);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 exc", {31'd0, exc}, 32'd0);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      string tg;
      comp_en = VECS[i].comp;
      do_write(2'd0, {24'd0, VECS[i].st});
      do_write(2'd1, VECS[i].sepc);
      do_write(2'd2, VECS[i].mepc);
      do_write(2'd3, {30'd0, VECS[i].priv});
      tg = $sformatf("R%0d vec%0d", VECS[i].req, i);
      check({tg, " setup status R2"}, {24'd0, status}, {24'd0, VECS[i].st});
      do_return(VECS[i].kind);
      check({tg, " exc R10"}, {31'd0, exc}, {31'd0, VECS[i].exc});
      check({tg, " done R10"}, {31'd0, done}, {31'd0, !VECS[i].exc});
      if (VECS[i].exc) begin
        check({tg, " cause"}, {28'd0, cause}, {28'd0, VECS[i].cause});
        check({tg, " priv held R7"}, {30'd0, priv}, {30'd0, VECS[i].epriv});
        check({tg, " status held R7"}, {24'd0, status}, {24'd0, VECS[i].est});
      end else begin
        check({tg, " target"}, target, VECS[i].epc);
        check({tg, " priv"}, {30'd0, priv}, {30'd0, VECS[i].epriv});
        check({tg, " status"}, {24'd0, status}, {24'd0, VECS[i].est});
      end
      @(negedge clk);
      check({tg, " pulse drop R10"}, {30'd0, done, exc}, 32'd0);
    end
    comp_en = 1'b0;

    // R2 legalisation of the reserved privilege encoding
    do_write(2'd0, 32'h0000_00DF);
    check("R2 mpp 2 stored as 0", {24'd0, status}, 32'h9F);
    do_write(2'd3, 32'd2);
    check("R2 priv 2 stored as 0", {30'd0, priv}, 32'd0);

    // R10 no request, no pulse
    @(negedge clk);
    check("R10 idle", {30'd0, done, exc}, 32'd0);

    // R11 write in the same cycle as a return is discarded
    do_write(2'd3, 32'd3);
    do_write(2'd2, 32'h400);
    do_write(2'd0, 32'h68);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'hFF;
    do_return(1'b1);
    wr_en = 1'b0;
    check("R11 done", {31'd0, done}, 32'd1);
    check("R11 status pop only", {24'd0, status}, 32'h02);
    @(negedge clk);
    check("R11 status later", {24'd0, status}, 32'h02);

    // R11 epc write with return discarded; R9 target reuses old mepc
    do_write(2'd0, 32'h68);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h800;
    do_return(1'b1);
    wr_en = 1'b0;
    check("R11 target", target, 32'h400);
    @(negedge clk);
    do_write(2'd0, 32'h68);
    do_return(1'b1);
    check("R11 mepc unchanged", target, 32'h400);

    report();
  end

endmodule